// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire bus slave that holds a small bank of 8-bit configuration registers and lets an external bus master write and read them. A fast system clock oversamples the serial clock and serial data lines. The block recognises bus start, repeated start and stop conditions. It answers a group of device addresses that share a fixed upper nibble and acknowledges every byte it accepts. It only ever pulls the data line low, through an active-high output-enable that external logic turns into an open-drain pull-down.

A write transfer sets an internal register pointer from the byte after the device address and then stores each following byte at the pointer, advancing it each time. A read transfer streams register contents out MSB first from the pointer. The usual way to read a chosen register is a pointer-setting write, a repeated start, and the device address with the read bit set. Every register is also presented on a wide parallel output for use by the surrounding logic.

Top module: `i2c_cfg_regs`

## Requirements
- R1: After reset every register reads 0, the register pointer is 0 and `sda_oe` is 0.
- R2: A falling SDA while SCL is high (START) begins a new address phase at any point in a transfer. A rising SDA while SCL is high (STOP) ends the transfer and leaves `sda_oe` at 0. Both lines pass through a two-stage synchroniser first.
- R3: In the first byte after a START, bits [7:4] must equal 4'b1010 for the slave to respond. Bits [3:1] are don't-care, and bit 0 is the direction (0 write, 1 read). All bytes go MSB first.
- R4: While addressed, the slave holds SDA low (`sda_oe`=1) through the ninth SCL pulse after each byte it receives. `sda_oe` changes only while SCL is low, except when a START or STOP releases it.
- R5: If the address does not match, the slave never asserts `sda_oe` and accepts no byte until the next START.
- R6: In a write transfer, the low four bits of the byte after the address load the pointer and the upper four bits are ignored. Each later byte is written to the register the pointer selects.
- R7: The pointer advances by one, modulo 16, after every data byte written. Byte 17 of a long write therefore overwrites the first register written.
- R8: A data byte cut short by a STOP or a repeated START changes no register.
- R9: In a read transfer, the slave drives the pointed register MSB first. The pointer advances by one, modulo 16, after each byte, and the pointer kept from earlier transfers is used.
- R10: When the master leaves the acknowledge bit of a read byte high, the slave releases SDA and sends nothing more until the next START or STOP.
- R11: Register n appears on `regs_o[8n+7:8n]` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | 128 | All sixteen registers, register n at bits [8n+7:8n] |

## Verification
The bench drives several kinds of transfer. A short write starting mid-bank shows that the pointer loads correctly. A write of 20 bytes starting near the top of the bank separates wrap-around from saturation. A pointer byte with its upper bits set shows that only the low nibble is used. A device address with non-zero don't-care bits shows that bits [3:1] are ignored, and a foreign address shows that the slave stays silent and ignores what follows. Random reads, a read that continues from the pointer left by an earlier transfer, and a read across the top of the bank check the order of the data and the pointer steps. Writes cut short by STOP and by repeated START separate discarding a partial byte from committing it.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic id_match(input logic [BYTE_W-1:0] b, input logic [3:0] id);
        return b[BYTE_W-1 -: 4] == id;
    endfunction

endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense
    import i2c_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_pipe[SYNC_STAGES-1];
        ev.sda      = sda_pipe[SYNC_STAGES-1];
        ev.scl_rise = ev.scl & ~scl_q;
        ev.scl_fall = ~ev.scl & scl_q;
        ev.start    = ev.scl & scl_q & sda_q & ~ev.sda;
        ev.stop     = ev.scl & scl_q & ~sda_q & ev.sda;
    end

    AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop)) else $error("start and stop together"); // R2

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int PTR_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [PTR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [PTR_W-1:0]           rd_addr,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    logic [BYTE_W-1:0] mem [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (wr_en && wr_addr == PTR_W'(i)) begin
                mem[i] <= wr_data;
            end
        end
        assign regs_flat[i*BYTE_W +: BYTE_W] = mem[i];
    end

    assign rd_data = mem[rd_addr];

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_flat)) else $error("register changed without write"); // R8

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS = 16,
    parameter logic [3:0] DEV_ID   = 4'b1010,
    localparam int        PTR_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);
    phase_e            phase;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              rw;
    logic              nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            rw      <= 1'b0;
            nack    <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                phase  <= ST_DEVADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                phase  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    ST_DEVADDR, ST_PTR, ST_WDATA: begin
                        if (ev.scl_rise && cnt != 4'd8) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (ev.scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (phase == ST_DEVADDR) begin
                                if (id_match(shreg, DEV_ID)) begin
                                    rw     <= shreg[0];
                                    sda_oe <= 1'b1;
                                    phase  <= ST_DEV_ACK;
                                end else begin
                                    phase  <= ST_IGNORE;
                                end
                            end else if (phase == ST_PTR) begin
                                ptr    <= shreg[PTR_W-1:0];
                                sda_oe <= 1'b1;
                                phase  <= ST_PTR_ACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 1'b1;
                                sda_oe  <= 1'b1;
                                phase   <= ST_WACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                phase  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_WACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            phase  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_fall) begin
                            if (cnt == 4'd7) begin
                                cnt    <= '0;
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                phase  <= ST_RACK;
                            end else begin
                                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~txreg[BYTE_W-2];
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            nack <= ev.sda;
                        end else if (ev.scl_fall) begin
                            if (nack) begin
                                phase <= ST_IGNORE;
                            end else begin
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                phase  <= ST_RDATA;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(ev.start || ev.stop)) |-> !ev.scl)
        else $error("sda_oe changed while SCL high"); // R4
    AST_SILENT_UNADDRESSED: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_IGNORE || phase == ST_IDLE) |-> !sda_oe)
        else $error("driving SDA while not addressed"); // R5
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe) else $error("SDA held after stop"); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ptr == PTR_W'(wr_addr + 1'b1)) else $error("pointer did not advance"); // R7

endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS    = 16,
    parameter logic [3:0] DEV_ID      = 4'b1010,
    parameter int         SYNC_STAGES = 2,
    localparam int        PTR_W       = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    bus_ev_t           ev;
    logic [PTR_W-1:0]  ptr;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;

    i2c_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_slave_fsm #(.NUM_REGS(NUM_REGS), .DEV_ID(DEV_ID)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (rd_data),
        .ptr     (ptr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (ptr),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && regs_o == '0)) else $error("reset state wrong"); // R1

endmodule

// File: tb/i2c_cfg_regs_tb.sv
module i2c_cfg_regs_tb;
    localparam int H = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_oe;
    logic [127:0] regs_o;
    wire          sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit cmp_en = 1'b0;
    bit silent = 1'b0;

    logic [7:0] mdl [16];
    int         mptr = 0;

    always #4 clk = ~clk;

    i2c_cfg_regs u_dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .regs_o (regs_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Register image compared with the model on every clock (R11, R6, R7, R8)
    always @(negedge clk) begin
        if (!rst && cmp_en && !done) begin
            for (int i = 0; i < 16; i++) begin
                chk("R11 reg image", int'(regs_o[8*i +: 8]), int'(mdl[i]));
            end
        end
        if (!rst && silent && !done) begin
            chk("R5 silent", int'(sda_oe), 0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic bit_io(input logic b, output logic s);
        sda_m = b; tick(H);
        scl_m = 1'b1; tick(H/2);
        s = sda_line; tick(H/2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b, output logic rel);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            b[i] = s;
        end
        bit_io(~mack, s);
        rel = s;
    endtask

    task automatic wr_data(input logic [7:0] d, input string req);
        logic a;
        cmp_en = 1'b0;
        send_byte(d, a);
        chk(req, int'(a), 1);
        mdl[mptr] = d;
        mptr = (mptr + 1) % 16;
        cmp_en = 1'b1;
    endtask

    task automatic wr_head(input logic [7:0] dev, input logic [7:0] p);
        logic a;
        bus_start();
        send_byte(dev, a);
        chk("R3 address ack", int'(a), 1);
        send_byte(p, a);
        chk("R6 pointer ack", int'(a), 1);
        mptr = int'(p[3:0]);
    endtask

    task automatic rd_bytes(input int n, input string req);
        logic [7:0] b;
        logic       rel;
        for (int i = 0; i < n; i++) begin
            read_byte(i != n-1, b, rel);
            chk(req, int'(b), int'(mdl[mptr]));
            mptr = (mptr + 1) % 16;
            if (i == n-1) chk("R10 released on nack", int'(rel), 1);
        end
    endtask

    initial begin
        logic a;
        logic s;
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 regs", int'(regs_o == '0), 1);
        cmp_en = 1'b1;

        // R6 short write from mid-bank
        wr_head(8'hA0, 8'h03);
        wr_data(8'h11, "R6 data ack");
        wr_data(8'h22, "R6 data ack");
        wr_data(8'h33, "R6 data ack");
        bus_stop();
        chk("R2 released after stop", int'(sda_oe), 0);

        // R9 random read via repeated start
        wr_head(8'hA0, 8'h03);
        bus_rstart();
        send_byte(8'hA1, a);
        chk("R9 read address ack", int'(a), 1);
        rd_bytes(3, "R9 read data");
        bus_stop();

        // R9 read continuing from kept pointer (6)
        bus_start();
        send_byte(8'hA1, a);
        chk("R9 read address ack", int'(a), 1);
        rd_bytes(1, "R9 kept pointer read");
        bus_stop();

        // R7 long write wraps
        wr_head(8'hA0, 8'h0E);
        for (int i = 0; i < 20; i++) wr_data(8'(i*7 + 1), "R7 wrap write ack");
        bus_stop();

        // R9 read across the top of the bank
        wr_head(8'hA0, 8'h0F);
        bus_rstart();
        send_byte(8'hA1, a);
        rd_bytes(2, "R9 wrap read");
        bus_stop();

        // R6 upper pointer bits ignored
        wr_head(8'hA0, 8'hF2);
        wr_data(8'h5A, "R6 high pointer bits");
        bus_stop();
        chk("R6 reg2", int'(regs_o[23:16]), 8'h5A);

        // R3 don't-care address bits
        wr_head(8'hAE, 8'h09);
        wr_data(8'hC3, "R3 alt address data");
        bus_stop();
        chk("R3 reg9", int'(regs_o[79:72]), 8'hC3);

        // R5 foreign address ignored
        bus_start();
        silent = 1'b1;
        send_byte(8'h90, a);
        chk("R5 no ack", int'(a), 0);
        send_byte(8'hA0, a);
        chk("R5 later byte ignored", int'(a), 0);
        send_byte(8'h44, a);
        chk("R5 later byte ignored", int'(a), 0);
        bus_stop();
        silent = 1'b0;

        // R8 partial byte then STOP
        wr_head(8'hA0, 8'h05);
        for (int i = 0; i < 4; i++) bit_io(1'b0, s);
        bus_stop();
        chk("R8 stop abort reg5", int'(regs_o[47:40]), int'(mdl[5]));

        // R8 partial byte then repeated START, then read reg5
        wr_head(8'hA0, 8'h05);
        for (int i = 0; i < 5; i++) bit_io(1'b1, s);
        bus_rstart();
        send_byte(8'hA1, a);
        chk("R2 restart mid-byte address ack", int'(a), 1);
        mptr = 5;
        rd_bytes(1, "R8 rstart abort read");
        bus_stop();
        chk("R8 rstart abort reg5", int'(regs_o[47:40]), int'(mdl[5]));
        chk("R2 final release", int'(sda_oe), 0);

        finish_run();
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule